// File: doc/BRIEF.md
# Overlapping Serial 1010 Recognizer

This block watches a single-bit serial stream, taking one bit per clock, and raises a one-cycle flag each time the four most recent bits, oldest first, read 1, 0, 1, 0. Matches may share bits. After a match, the trailing "10" already counts as the first half of the next candidate, so the stream 1010 10 flags twice.

The recognizer is a Moore machine with five states that track the longest useful prefix seen so far: nothing, "1", "10", "101" and the full "1010". The flag is held in a register and decoded from the next state, so it rises in the cycle right after the clock edge that samples the closing 0. Within the flag's cycle it is aligned with the bit that was just sampled. A synchronous reset returns the machine to the empty-prefix state with the flag low.

Top module: `serial_pat_recog`

## Requirements
- R1: In the cycle after any clock edge that samples `rst` high, `z_out` is 0 and the machine holds the empty-prefix state, so no earlier bits count toward a match.
- R2: After the edge that samples a `x_in` of 0 that completes the bit order 1,0,1,0 (oldest first), `z_out` is 1 in the following cycle.
- R3: `z_out` is 0 after every edge at which the last four sampled bits are not 1,0,1,0.
- R4: Matches overlap. In the stream 1,0,1,0,1,0, `z_out` is 1 after the 4th bit and again after the 6th bit.
- R5: For the input stream 00101001010101110, the per-bit `z_out` seen after each sampling edge is 00000100001010000.
- R6: Any run of leading 1s before "010" still matches. For example, 1,1,1,0,1,0 gives a pulse after the last bit only.
- R7: After a match, a further 0 clears all partial progress. For example, 1,0,1,0,0,1,0 gives no second pulse.
- R8: A reset in the middle of a pattern discards the partial match. For example, 1,0,1 then reset then 0 gives no pulse.
- R9: `z_out` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Serial data bit sampled on each rising edge |
| z_out | output | 1 | Registered match flag, high for one cycle per match |

## Verification
A wrong state encoding or a wrong fallback edge shows up as a missing or extra flag. Because no state is more than four samples away from a flag decision, any error is visible at `z_out` within at most four clocks of the bit that caused it. Overlap errors, such as falling back to idle instead of to "10" after a hit, show up as the missing second pulse in runs of alternating 1s and 0s. Errors in the "1" self-loop show up as missed matches after runs of 1s.

// File: rtl/serial_pat_recog_pkg.sv
package serial_pat_recog_pkg;

    // Prefix-tracking states of the recognizer
    typedef enum logic [2:0] {
        ST_NONE   = 3'd0,   // no useful prefix
        ST_P1     = 3'd1,   // "1"
        ST_P10    = 3'd2,   // "10"
        ST_P101   = 3'd3,   // "101"
        ST_HIT    = 3'd4    // "1010" complete
    } spr_state_e;

    typedef struct packed {
        spr_state_e state;
        logic       flag;
    } spr_regs_t;

    localparam spr_regs_t SPR_RESET = '{state: ST_NONE, flag: 1'b0};

endpackage

// File: rtl/spr_next.sv
module spr_next
    import serial_pat_recog_pkg::*;
(
    input  spr_state_e cur_state,
    input  logic       bit_in,
    output spr_state_e nxt_state
);

    always_comb begin
        nxt_state = ST_NONE;
        unique case (cur_state)
            ST_NONE: nxt_state = bit_in ? ST_P1   : ST_NONE;
            ST_P1:   nxt_state = bit_in ? ST_P1   : ST_P10;
            ST_P10:  nxt_state = bit_in ? ST_P101 : ST_NONE;
            ST_P101: nxt_state = bit_in ? ST_P1   : ST_HIT;
            ST_HIT:  nxt_state = bit_in ? ST_P101 : ST_NONE;
            default: nxt_state = ST_NONE;
        endcase
    end

endmodule

// File: rtl/spr_out.sv
module spr_out
    import serial_pat_recog_pkg::*;
(
    input  spr_state_e st,
    output logic       hit
);

    always_comb begin
        hit = (st == ST_HIT);
    end

endmodule

// File: rtl/serial_pat_recog.sv
module serial_pat_recog
    import serial_pat_recog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x_in,
    output logic z_out
);

    spr_regs_t  regs_d, regs_q;
    spr_state_e nxt_w;
    logic       hit_w;

    spr_next u_next (
        .cur_state (regs_q.state),
        .bit_in    (x_in),
        .nxt_state (nxt_w)
    );

    spr_out u_out (
        .st  (nxt_w),
        .hit (hit_w)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = nxt_w;
        regs_d.flag  = hit_w;
        if (rst) begin
            regs_d = SPR_RESET;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign z_out = regs_q.flag;

    // Independent history of sampled bits, for the checks below
    logic [2:0] hist_q;
    logic [1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 3'b000;
            seen_q <= 2'd0;
        end else begin
            hist_q <= {hist_q[1:0], x_in};
            if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!z_out && regs_q.state == ST_NONE));                    // R1
    AST_MATCH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (seen_q == 2'd3 && hist_q == 3'b101 && !x_in) |=> z_out);              // R2
    AST_NO_FALSE_FLAG: assert property (@(posedge clk) disable iff (rst)
        !(seen_q == 2'd3 && hist_q == 3'b101 && !x_in) |=> !z_out);            // R3
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        z_out |=> !z_out);                                                      // R9

endmodule

// File: tb/serial_pat_recog_tb.sv
module serial_pat_recog_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_in = 1'b0;
    logic z_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    serial_pat_recog u_dut (
        .clk   (clk),
        .rst   (rst),
        .x_in  (x_in),
        .z_out (z_out)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s z_out=%b expected=%b", tag, act, exp);
        end
    endtask

    // drive at negedge, sample after the next rising edge
    task automatic send_bit(input logic b, input logic exp, input string tag);
        @(negedge clk);
        x_in = b;
        @(posedge clk);
        #1;
        check(z_out, exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        x_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(z_out, 1'b0, "R1 reset state");
        send_bit(1'b0, 1'b0, "R1 idle after reset");
    endtask

    task automatic t_example();
        logic [16:0] xs = 17'b00101001010101110;
        logic [16:0] zs = 17'b00000100001010000;
        do_reset();
        for (int i = 16; i >= 0; i--)
            send_bit(xs[i], zs[i], "R5 example stream");
    endtask

    task automatic t_basic();
        do_reset();
        send_bit(1, 0, "R3 partial 1");
        send_bit(0, 0, "R3 partial 10");
        send_bit(1, 0, "R3 partial 101");
        send_bit(0, 1, "R2 match 1010");
        send_bit(1, 0, "R9 one cycle pulse");
        send_bit(0, 1, "R4 overlap second hit");
        send_bit(1, 0, "R9 no repeat");
        send_bit(0, 1, "R4 overlap third hit");
    endtask

    task automatic t_ones();
        do_reset();
        send_bit(1, 0, "R6 ones");
        send_bit(1, 0, "R6 ones");
        send_bit(1, 0, "R6 ones");
        send_bit(0, 0, "R6 ones then 0");
        send_bit(1, 0, "R6 ones 101");
        send_bit(0, 1, "R6 match after run of ones");
    endtask

    task automatic t_break();
        do_reset();
        send_bit(1, 0, "R7 lead");
        send_bit(0, 0, "R7 lead");
        send_bit(1, 0, "R7 lead");
        send_bit(0, 1, "R7 first match");
        send_bit(0, 0, "R7 extra zero");
        send_bit(1, 0, "R7 restart 1");
        send_bit(0, 0, "R7 no second match");
    endtask

    task automatic t_mid_reset();
        do_reset();
        send_bit(1, 0, "R8 partial");
        send_bit(0, 0, "R8 partial");
        send_bit(1, 0, "R8 partial");
        do_reset();
        check(z_out, 1'b0, "R8 reset low");
        send_bit(0, 0, "R8 partial discarded");
    endtask

    initial begin
        t_reset();
        t_example();
        t_basic();
        t_ones();
        t_break();
        t_mid_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule